// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on independent clocks. Each side has its own active-low enable. The data path is 18 bits wide and the depth is a power of two. The write side stores a word on each enabled write clock edge unless the buffer is full. The read side moves the oldest word into an output register on each enabled read clock edge unless the buffer is empty. An output-enable input gates the data outputs and reports the gating on a separate drive signal.

Five active-low level flags report the fill state: empty, almost empty, half full, almost full and full. The almost thresholds come from two offset inputs. A mode input chooses how the almost flags are produced. They can be registered in their own clock domain, or decoded combinationally from the current word count. Pointers cross between the domains as Gray code through two-flop synchronisers. As a result, full-type flags err towards full and empty-type flags err towards empty.

A retransmit pulse sampled on the read clock moves the read pointer back to the first storage location. The stored data can then be read again. This is defined only while the number of writes since reset does not exceed the depth.

Top module: `dcfifo_pflags`

## Requirements
- R1: A write happens on a rising `wclk_i` edge when `wen_ni` is 0 and `full_no` is 1. While `full_no` is 0 no word is stored, whatever `wen_ni` does.
- R2: A read happens on a rising `rclk_i` edge when `ren_ni` is 0, `empty_no` is 1 and `rt_i` is 0. While `empty_no` is 0 the read pointer and the output register keep their values, so `rdata_o` keeps the last word read.
- R3: Words come out of `rdata_o` in the order they were accepted, one per read. `rdata_o` is valid just after the read clock edge that performed the read.
- R4: `full_no` is 0 exactly when the write-side count is DEPTH, and it is updated only on `wclk_i`. `empty_no` is 0 exactly when the read-side count is 0, and it is updated only on `rclk_i`.
- R5: `half_no` is 0 when the write-side count is greater than DEPTH/2. It is 1 at DEPTH/2 words or fewer. It is registered on `wclk_i`.
- R6: `aempty_no` is 0 when the count is at most `ae_off_i`. `afull_no` is 0 when the count is at least DEPTH − `af_off_i`. A system value of 127 is typical for both offsets.
- R7: With `async_mode_i` = 0, `afull_no` is registered on `wclk_i` and `aempty_no` is registered on `rclk_i`, so an offset change shows only after the next edge of that clock. With `async_mode_i` = 1, both flags are decoded combinationally and follow an offset change without a clock edge.
- R8: A 1 on `rt_i` at a rising `rclk_i` edge sets the read pointer to location 0. Later reads replay the stored words in order until the read pointer meets the write pointer, and the flags follow the new pointer positions.
- R9: While `rst_ni` is 0: `empty_no` = 0, `aempty_no` = 0, `full_no` = 1, `afull_no` = 1, `half_no` = 1, and the output register is 0.
- R10: `oe_ni` = 1 forces `q_drive_o` to 0 and `rdata_o` to 0. `oe_ni` = 0 sets `q_drive_o` to 1 and shows the output register on `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| wen_ni | input | 1 | Write enable, active low |
| wdata_i | input | DATA_W | Write data |
| ren_ni | input | 1 | Read enable, active low |
| rt_i | input | 1 | Retransmit, sampled on rclk_i |
| oe_ni | input | 1 | Output enable, active low |
| async_mode_i | input | 1 | 1: combinational almost flags, 0: registered |
| ae_off_i | input | log2(DEPTH) | Almost-empty offset n |
| af_off_i | input | log2(DEPTH) | Almost-full offset m |
| rdata_o | output | DATA_W | Output register, zero while not driven |
| q_drive_o | output | 1 | 1 when the data outputs drive |
| empty_no | output | 1 | Empty, active low |
| aempty_no | output | 1 | Almost empty, active low |
| half_no | output | 1 | More than half full, active low |
| afull_no | output | 1 | Almost full, active low |
| full_no | output | 1 | Full, active low |

## Verification
The bench fills the buffer to exactly DEPTH and checks the full, half and almost-full boundaries on every write. A counting error of one would move a flag by one word. The bench then writes once more while full; a design that let this word through would show an extra word during the drain. It reads on empty and expects the last word to stay on the outputs, which catches a pointer that wraps or an output register that reloads. It retransmits after a full-depth fill and expects the whole sequence again, which exposes a rewind to the wrong place or a lost empty update. Finally, it changes an offset between clock edges in both almost-flag modes and expects an instant change only in combinational mode.

// File: rtl/fifo_pflags_pkg.sv
package fifo_pflags_pkg;
  typedef enum logic {
    FLAG_REG  = 1'b0,
    FLAG_COMB = 1'b1
  } flag_mode_e;

  localparam int DATA_W_DEF = 18;
  localparam int DEPTH_DEF  = 256;
endpackage

// File: rtl/fifo_gray_sync.sv
// Two-flop synchroniser for a Gray pointer, decoded to binary after the second flop.
module fifo_gray_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_dec
    assign bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // Output register: holds the last word read
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic [AW:0]   rptr_bin_i,
  input  logic [AW-1:0] af_off_i,
  input  logic          async_mode_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wptr_o,
  output logic [AW:0]   wptr_gray_o,
  output logic          full_no,
  output logic          afull_no,
  output logic          half_no
);
  import fifo_pflags_pkg::*;

  localparam int PW = AW + 1;
  localparam logic [AW:0] DEPTH_V = PW'(1) << AW;
  localparam logic [AW:0] HALF_V  = PW'(1) << (AW - 1);

  logic [AW:0] wptr_q, wptr_nxt, cnt_now, cnt_nxt, af_thr;
  logic        full_q_n, afull_q_n, half_q_n;

  assign we_o     = !wen_ni && full_q_n;
  assign wptr_nxt = wptr_q + PW'(we_o);
  assign cnt_now  = wptr_q - rptr_bin_i;
  assign cnt_nxt  = wptr_nxt - rptr_bin_i;
  assign af_thr   = DEPTH_V - {1'b0, af_off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q      <= '0;
      wptr_gray_o <= '0;
      full_q_n    <= 1'b1;
      afull_q_n   <= 1'b1;
      half_q_n    <= 1'b1;
    end else begin
      wptr_q      <= wptr_nxt;
      wptr_gray_o <= wptr_nxt ^ (wptr_nxt >> 1);
      full_q_n    <= !(cnt_nxt == DEPTH_V);
      afull_q_n   <= !(cnt_nxt >= af_thr);
      half_q_n    <= !(cnt_nxt > HALF_V);
    end
  end

  assign waddr_o  = wptr_q[AW-1:0];
  assign wptr_o   = wptr_q;
  assign full_no  = full_q_n;
  assign half_no  = half_q_n;
  assign afull_no = (flag_mode_e'(async_mode_i) == FLAG_COMB) ? !(cnt_now >= af_thr) : afull_q_n;
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_ni,
  input  logic          rt_i,
  input  logic [AW:0]   wptr_bin_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic          async_mode_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rptr_o,
  output logic [AW:0]   rptr_gray_o,
  output logic          empty_no,
  output logic          aempty_no
);
  import fifo_pflags_pkg::*;

  localparam int PW = AW + 1;

  logic [AW:0] rptr_q, rptr_nxt, cnt_now, cnt_nxt, ae_thr;
  logic        empty_q_n, aempty_q_n;

  // Retransmit wins over a read in the same cycle
  assign re_o     = !ren_ni && empty_q_n && !rt_i;
  assign rptr_nxt = rt_i ? '0 : rptr_q + PW'(re_o);
  assign cnt_now  = wptr_bin_i - rptr_q;
  assign cnt_nxt  = wptr_bin_i - rptr_nxt;
  assign ae_thr   = {1'b0, ae_off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q      <= '0;
      rptr_gray_o <= '0;
      empty_q_n   <= 1'b0;
      aempty_q_n  <= 1'b0;
    end else begin
      rptr_q      <= rptr_nxt;
      rptr_gray_o <= rptr_nxt ^ (rptr_nxt >> 1);
      empty_q_n   <= (cnt_nxt != '0);
      aempty_q_n  <= !(cnt_nxt <= ae_thr);
    end
  end

  assign raddr_o   = rptr_q[AW-1:0];
  assign rptr_o    = rptr_q;
  assign empty_no  = empty_q_n;
  assign aempty_no = (flag_mode_e'(async_mode_i) == FLAG_COMB) ? !(cnt_now <= ae_thr) : aempty_q_n;
endmodule

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags #(
  parameter int DATA_W = fifo_pflags_pkg::DATA_W_DEF,
  parameter int DEPTH  = fifo_pflags_pkg::DEPTH_DEF,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wen_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren_ni,
  input  logic              rt_i,
  input  logic              oe_ni,
  input  logic              async_mode_i,
  input  logic [AW-1:0]     ae_off_i,
  input  logic [AW-1:0]     af_off_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              q_drive_o,
  output logic              empty_no,
  output logic              aempty_no,
  output logic              half_no,
  output logic              afull_no,
  output logic              full_no
);
  logic              we, re;
  logic [AW-1:0]     waddr, raddr;
  logic [AW:0]       wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [AW:0]       wptr_rsync, rptr_wsync;
  logic [DATA_W-1:0] rdata_q;

  fifo_wr_side #(.AW(AW)) u_wr (
    .clk_i       (wclk_i),
    .rst_ni      (rst_ni),
    .wen_ni      (wen_ni),
    .rptr_bin_i  (rptr_wsync),
    .af_off_i    (af_off_i),
    .async_mode_i(async_mode_i),
    .we_o        (we),
    .waddr_o     (waddr),
    .wptr_o      (wptr_bin),
    .wptr_gray_o (wptr_gray),
    .full_no     (full_no),
    .afull_no    (afull_no),
    .half_no     (half_no)
  );

  fifo_rd_side #(.AW(AW)) u_rd (
    .clk_i       (rclk_i),
    .rst_ni      (rst_ni),
    .ren_ni      (ren_ni),
    .rt_i        (rt_i),
    .wptr_bin_i  (wptr_rsync),
    .ae_off_i    (ae_off_i),
    .async_mode_i(async_mode_i),
    .re_o        (re),
    .raddr_o     (raddr),
    .rptr_o      (rptr_bin),
    .rptr_gray_o (rptr_gray),
    .empty_no    (empty_no),
    .aempty_no   (aempty_no)
  );

  fifo_gray_sync #(.W(AW + 1)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .gray_i(wptr_gray),
    .bin_o (wptr_rsync)
  );

  fifo_gray_sync #(.W(AW + 1)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .gray_i(rptr_gray),
    .bin_o (rptr_wsync)
  );

  fifo_mem #(.DW(DATA_W), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (re),
    .raddr_i(raddr),
    .rdata_o(rdata_q)
  );

  assign q_drive_o = !oe_ni;
  assign rdata_o   = oe_ni ? '0 : rdata_q;
endmodule

// File: rtl/dcfifo_pflags_chk.sv
module dcfifo_pflags_chk #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          rt_i,
  input logic          oe_ni,
  input logic          async_mode_i,
  input logic          empty_no,
  input logic          aempty_no,
  input logic          half_no,
  input logic          afull_no,
  input logic          full_no,
  input logic          q_drive_o,
  input logic [DW-1:0] rdata_o,
  input logic [AW:0]   wptr_i,
  input logic [AW:0]   rptr_i,
  input logic [DW-1:0] rdq_i
);
  p_no_overflow_r1: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> wptr_i == $past(wptr_i));

  p_no_underflow_r2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_no && !rt_i) |=> (rptr_i == $past(rptr_i)) && (rdq_i == $past(rdq_i)));

  p_full_dominates_r5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> (!half_no && (async_mode_i || !afull_no)));

  p_empty_implies_ae_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!async_mode_i && !empty_no) |-> !aempty_no);

  p_rt_rewind_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rt_i |=> rptr_i == '0);

  p_hiz_r10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    oe_ni |-> (!q_drive_o && rdata_o == '0));
endmodule

bind dcfifo_pflags dcfifo_pflags_chk #(.AW(AW), .DW(DATA_W)) u_chk (
  .wclk_i      (wclk_i),
  .rclk_i      (rclk_i),
  .rst_ni      (rst_ni),
  .rt_i        (rt_i),
  .oe_ni       (oe_ni),
  .async_mode_i(async_mode_i),
  .empty_no    (empty_no),
  .aempty_no   (aempty_no),
  .half_no     (half_no),
  .afull_no    (afull_no),
  .full_no     (full_no),
  .q_drive_o   (q_drive_o),
  .rdata_o     (rdata_o),
  .wptr_i      (wptr_bin),
  .rptr_i      (rptr_bin),
  .rdq_i       (rdata_q)
);

// File: tb/dcfifo_pflags_bench.sv
module dcfifo_pflags_bench;
  localparam int DW    = 18;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          wclk = 0, rclk = 0, rst_ni = 0;
  logic          wen_ni = 1, ren_ni = 1, rt_i = 0, oe_ni = 0, async_mode_i = 0;
  logic [DW-1:0] wdata_i = '0;
  logic [AW-1:0] ae_off_i = 4'd3, af_off_i = 4'd4;
  logic [DW-1:0] rdata_o;
  logic          q_drive_o, empty_no, aempty_no, half_no, afull_no, full_no;

  int            n_chk = 0, n_bad = 0, rx_cnt = 0;
  bit            done = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] hist[$];
  logic [DW-1:0] last_w;

  always #10 wclk = ~wclk;
  initial begin #7; forever #10 rclk = ~rclk; end

  dcfifo_pflags #(.DATA_W(DW), .DEPTH(DEPTH)) u_dcfifo_pflags (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .wen_ni(wen_ni), .wdata_i(wdata_i),
    .ren_ni(ren_ni), .rt_i(rt_i), .oe_ni(oe_ni), .async_mode_i(async_mode_i),
    .ae_off_i(ae_off_i), .af_off_i(af_off_i), .rdata_o(rdata_o), .q_drive_o(q_drive_o),
    .empty_no(empty_no), .aempty_no(aempty_no), .half_no(half_no), .afull_no(afull_no),
    .full_no(full_no)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on every read the port rules allow
  always @(posedge rclk) begin
    if (rst_ni && !ren_ni && empty_no && !rt_i) begin
      #2;
      if (exp_q.size() == 0) chk("R3 unexpected read", 32'(rdata_o), 32'hDEAD);
      else chk("R3 order", 32'(rdata_o), 32'(exp_q.pop_front()));
      rx_cnt++;
    end
  end

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk);
    wen_ni  = 0;
    wdata_i = d;
    if (full_no) begin
      exp_q.push_back(d);
      hist.push_back(d);
      last_w = d;
    end
  endtask

  task automatic rd();
    @(negedge rclk);
    ren_ni = 0;
  endtask

  task automatic do_reset();
    @(negedge wclk);
    rst_ni = 0; wen_ni = 1; ren_ni = 1; rt_i = 0;
    repeat (3) @(negedge wclk);
    exp_q.delete();
    hist.delete();
    rst_ni = 1;
    repeat (2) @(negedge wclk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9 reset state
    #35;
    chk("R9 empty", 32'(empty_no), 1'b0);
    chk("R9 aempty", 32'(aempty_no), 1'b0);
    chk("R9 full", 32'(full_no), 1'b1);
    chk("R9 afull", 32'(afull_no), 1'b1);
    chk("R9 half", 32'(half_no), 1'b1);
    chk("R9 rdata", 32'(rdata_o), 32'h0);
    chk("R10 drive", 32'(q_drive_o), 1'b1);
    do_reset();

    // R2 read on empty does nothing
    rd(); rd();
    @(negedge rclk); ren_ni = 1;
    chk("R2 empty read rdata", 32'(rdata_o), 32'h0);

    // Fill to DEPTH: R4 R5 R6 boundaries
    for (int k = 1; k <= DEPTH; k++) begin
      wr(18'(k * 18'h0153 ^ 18'h2AAAA));
      @(posedge wclk); #2;
      chk("R4 full on fill", 32'(full_no), (k == DEPTH) ? 1'b0 : 1'b1);
      chk("R5 half on fill", 32'(half_no), (k > DEPTH / 2) ? 1'b0 : 1'b1);
      chk("R6 afull on fill", 32'(afull_no), (k >= DEPTH - 4) ? 1'b0 : 1'b1);
    end
    // R1 write while full is dropped
    wr(18'h3FFFF);
    @(posedge wclk); #2;
    chk("R1 full held", 32'(full_no), 1'b0);
    @(negedge wclk); wen_ni = 1;
    repeat (6) @(negedge rclk);
    chk("R4 not empty", 32'(empty_no), 1'b1);
    chk("R6 aempty high", 32'(aempty_no), 1'b1);

    // Drain with flag checks
    for (int j = 1; j <= DEPTH; j++) begin
      rd();
      @(posedge rclk); #3;
      chk("R4 empty on drain", 32'(empty_no), (j == DEPTH) ? 1'b0 : 1'b1);
      chk("R6 aempty on drain", 32'(aempty_no), (DEPTH - j <= 3) ? 1'b0 : 1'b1);
    end
    rd(); rd();
    @(negedge rclk); ren_ni = 1;
    chk("R2 holds last word", 32'(rdata_o), 32'(last_w));
    chk("R1 no extra word", 32'(exp_q.size()), 32'd0);

    // R8 retransmit after exactly DEPTH writes
    @(negedge rclk); rt_i = 1;
    @(negedge rclk); rt_i = 0;
    #2;
    chk("R8 not empty after rewind", 32'(empty_no), 1'b1);
    foreach (hist[i]) exp_q.push_back(hist[i]);
    for (int j = 0; j < DEPTH; j++) rd();
    @(negedge rclk); ren_ni = 1;
    chk("R8 replay done", 32'(exp_q.size()), 32'd0);
    chk("R8 empty after replay", 32'(empty_no), 1'b0);

    // R7 almost-flag modes
    do_reset();
    for (int k = 0; k < 10; k++) wr(18'(18'h01000 + k));
    @(negedge wclk); wen_ni = 1;
    repeat (6) @(negedge wclk);
    chk("R6 afull below thr", 32'(afull_no), 1'b1);
    af_off_i = 4'd7;
    #2 chk("R7 registered afull waits", 32'(afull_no), 1'b1);
    @(posedge wclk); #2;
    chk("R7 registered afull after edge", 32'(afull_no), 1'b0);
    @(negedge wclk); af_off_i = 4'd4;
    @(posedge wclk); #2;
    chk("R7 afull restored", 32'(afull_no), 1'b1);
    @(negedge wclk); async_mode_i = 1; af_off_i = 4'd7;
    #2 chk("R7 comb afull immediate", 32'(afull_no), 1'b0);
    @(negedge rclk); ae_off_i = 4'd12;
    #2 chk("R7 comb aempty immediate", 32'(aempty_no), 1'b0);
    ae_off_i = 4'd3;
    #2 chk("R7 comb aempty release", 32'(aempty_no), 1'b1);
    @(negedge rclk); async_mode_i = 0; af_off_i = 4'd4; ae_off_i = 4'd12;
    #2 chk("R7 registered aempty waits", 32'(aempty_no), 1'b1);
    @(posedge rclk); #2;
    chk("R7 registered aempty after edge", 32'(aempty_no), 1'b0);
    @(negedge rclk); ae_off_i = 4'd3;

    // R10 output enable
    rd(); rd();
    @(negedge rclk); ren_ni = 1;
    oe_ni = 1;
    #2;
    chk("R10 drive off", 32'(q_drive_o), 1'b0);
    chk("R10 data zero", 32'(rdata_o), 32'h0);
    oe_ni = 0;
    #2 chk("R10 data back", 32'(rdata_o), 32'h01001);
    for (int j = 0; j < 8; j++) rd();
    @(negedge rclk); ren_ni = 1;

    // R3 concurrent streaming
    begin
      int target;
      target = rx_cnt + 40;
      fork
        begin
          int acc = 0;
          for (int c = 0; acc < 40; c++) begin
            @(negedge wclk);
            if (c % 4 == 3 || !full_no) wen_ni = 1;
            else begin
              wen_ni  = 0;
              wdata_i = 18'(18'h15000 + c * 7);
              exp_q.push_back(wdata_i);
              acc++;
            end
          end
          @(negedge wclk); wen_ni = 1;
        end
        begin
          for (int c = 0; rx_cnt < target; c++) begin
            @(negedge rclk);
            if (rx_cnt < target) ren_ni = (c % 3 == 2);
          end
          ren_ni = 1;
        end
      join
    end
    repeat (4) @(negedge rclk);
    chk("R3 stream drained", 32'(exp_q.size()), 32'd0);
    chk("R4 empty after stream", 32'(empty_no), 1'b0);
    finish_run();
  end
endmodule